// File: doc/BRIEF.md
# Scratchpad Register File with Default Select

This block is a small file of sixteen 16-bit temporary registers that share a single data bus. Fifteen select lines each pick one of registers 0 to 14. When none of them is raised, register 15 is the target. So the last register costs no select line, and an access with an all-zero select vector still has a defined destination.

Every access is qualified by exactly one strobe: read or write. A write stores the bus input on the clock edge. A read presents the chosen register on the registered data output, together with an enable flag, one cycle later. Two conditions are refused: two or more select lines raised together, and both strobes raised together. In either case no register changes, no read data is driven, and a registered error flag is raised for one cycle. The block is meant to serve as a temporary store next to a datapath that moves one word per cycle over a common bus.

Top module: `spad_regfile`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every register holds 0, `rdata_o` is 0, and `rdata_en_o` and `err_o` are low.
- R2: When bit i of `sel_i` (i from 0 to 14) is the only bit set, register i is the one read or written.
- R3: When `sel_i` is all zero, register 15 is the one read or written.
- R4: With `wr_i` high, `rd_i` low and a legal select, `wdata_i` is stored in the selected register at the rising clock edge.
- R5: With `rd_i` high, `wr_i` low and a legal select, the selected register appears on `rdata_o` with `rdata_en_o` high in the cycle after the request.
- R6: In every cycle after a cycle that had no legal read, `rdata_en_o` is low and `rdata_o` is 0.
- R7: With a strobe raised and two or more bits of `sel_i` set, no register changes, no read data is driven, and `err_o` is high in the next cycle.
- R8: With `rd_i` and `wr_i` both high, no register changes, no read data is driven, and `err_o` is high in the next cycle, whatever the select.
- R9: With neither strobe raised, no register changes and `err_o` stays low in the next cycle, even with several select bits set.
- R10: A read of a register in the cycle after a legal write to it returns the value just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 15 | One-hot select for registers 0..14; all zero selects register 15 |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Bus data to be written |
| rdata_o | output | 16 | Registered read data; zero when not enabled |
| rdata_en_o | output | 1 | Read data valid, high one cycle after a legal read |
| err_o | output | 1 | High one cycle after a refused access |

## Verification
In every cycle the assertions check how the two output flags relate to the strobes and select vector of the previous cycle. They check that the data output is zero when it is not enabled, that error and enable never appear together, and that a read right after a write to the same register returns the written word. Only the bench's reference model can show that each of the sixteen registers keeps its own contents. The same applies to showing that the default register 15 really is separate from registers 0 to 14, and that refused accesses leave every stored word untouched over long mixed sequences.

// File: rtl/spad_pkg.sv
package spad_pkg;
  // Default geometry of the scratchpad
  localparam int unsigned SPAD_DATA_W   = 16;
  localparam int unsigned SPAD_NUM_REGS = 16;

  // Per-cycle access decision
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_BAD   = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/spad_sel_decode.sv
module spad_sel_decode #(
  parameter int unsigned NUM_REGS = spad_pkg::SPAD_NUM_REGS,
  localparam int unsigned SEL_W = NUM_REGS - 1,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic [SEL_W-1:0] sel,
  output logic [IDX_W-1:0] idx,
  output logic             multi
);
  localparam int unsigned CNT_W = $clog2(NUM_REGS) + 1;

  logic [CNT_W-1:0] hot_cnt;

  // Count raised lines and encode the one that is raised;
  // an empty vector falls back to the last register.
  always_comb begin
    hot_cnt = '0;
    idx     = IDX_W'(NUM_REGS - 1);
    for (int i = 0; i < SEL_W; i++) begin
      if (sel[i]) begin
        hot_cnt = hot_cnt + CNT_W'(1);
        idx     = IDX_W'(i);
      end
    end
  end

  assign multi = (hot_cnt > CNT_W'(1));
endmodule

// File: rtl/spad_access_ctrl.sv
module spad_access_ctrl
  import spad_pkg::*;
(
  input  logic      rd,
  input  logic      wr,
  input  logic      multi,
  output acc_kind_e kind,
  output logic      do_rd,
  output logic      do_wr,
  output logic      refuse
);
  always_comb begin
    if (!rd && !wr)          kind = ACC_NONE;
    else if ((rd && wr) || multi) kind = ACC_BAD;
    else if (rd)             kind = ACC_READ;
    else                     kind = ACC_WRITE;
  end

  assign do_rd  = (kind == ACC_READ);
  assign do_wr  = (kind == ACC_WRITE);
  assign refuse = (kind == ACC_BAD);
endmodule

// File: rtl/spad_storage.sv
module spad_storage #(
  parameter int unsigned DATA_W   = spad_pkg::SPAD_DATA_W,
  parameter int unsigned NUM_REGS = spad_pkg::SPAD_NUM_REGS,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  // Single shared port: read and write never coincide
  assign rdata = mem[addr];
endmodule

// File: rtl/spad_regfile.sv
module spad_regfile #(
  parameter int unsigned DATA_W   = spad_pkg::SPAD_DATA_W,
  parameter int unsigned NUM_REGS = spad_pkg::SPAD_NUM_REGS,
  localparam int unsigned SEL_W = NUM_REGS - 1,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_en_o,
  output logic              err_o
);
  import spad_pkg::*;

  logic [IDX_W-1:0]  idx;
  logic              multi;
  acc_kind_e         kind;
  logic              do_rd;
  logic              do_wr;
  logic              refuse;
  logic [DATA_W-1:0] cell_q;

  spad_sel_decode #(
    .NUM_REGS(NUM_REGS)
  ) i_decode (
    .sel   (sel_i),
    .idx   (idx),
    .multi (multi)
  );

  spad_access_ctrl i_ctrl (
    .rd     (rd_i),
    .wr     (wr_i),
    .multi  (multi),
    .kind   (kind),
    .do_rd  (do_rd),
    .do_wr  (do_wr),
    .refuse (refuse)
  );

  spad_storage #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS)
  ) i_store (
    .clk   (clk),
    .rst   (rst),
    .we    (do_wr),
    .addr  (idx),
    .wdata (wdata_i),
    .rdata (cell_q)
  );

  // Registered bus-side outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o    <= '0;
      rdata_en_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      rdata_o    <= do_rd ? cell_q : '0;
      rdata_en_o <= do_rd;
      err_o      <= refuse;
    end
  end
endmodule

// File: rtl/spad_regfile_chk.sv
module spad_regfile_chk #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned SEL_W = NUM_REGS - 1
) (
  input logic              clk,
  input logic              rst,
  input logic [SEL_W-1:0]  sel_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rdata_en_o,
  input logic              err_o
);
  logic sel_ok;
  logic legal_rd;
  logic legal_wr;
  logic bad_req;

  assign sel_ok   = ($countones(sel_i) <= 1);
  assign legal_rd = rd_i && !wr_i && sel_ok;
  assign legal_wr = wr_i && !rd_i && sel_ok;
  assign bad_req  = (rd_i || wr_i) && !(legal_rd || legal_wr);

  AST_READ_ENABLE: assert property (@(posedge clk) disable iff (rst)
    legal_rd |=> rdata_en_o); // R5

  AST_NO_STRAY_ENABLE: assert property (@(posedge clk) disable iff (rst)
    !legal_rd |=> !rdata_en_o); // R6

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rdata_en_o |-> (rdata_o == '0)); // R6

  AST_REFUSE_FLAG: assert property (@(posedge clk) disable iff (rst)
    bad_req |=> (err_o && !rdata_en_o)); // R7

  AST_BOTH_STROBES: assert property (@(posedge clk) disable iff (rst)
    (rd_i && wr_i) |=> err_o); // R8

  AST_QUIET_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (!rd_i && !wr_i) |=> !err_o); // R9

  AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (rst)
    (legal_wr ##1 (legal_rd && sel_i == $past(sel_i))) |=> (rdata_o == $past(wdata_i, 2))); // R10
endmodule

bind spad_regfile spad_regfile_chk #(
  .DATA_W  (DATA_W),
  .NUM_REGS(NUM_REGS)
) i_spad_regfile_chk (
  .clk       (clk),
  .rst       (rst),
  .sel_i     (sel_i),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .rdata_en_o(rdata_en_o),
  .err_o     (err_o)
);

// File: tb/test_spad_regfile.sv
module test_spad_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NR = 16;
  localparam int SW = NR - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [SW-1:0] sel_i = '0;
  logic          rd_i = 1'b0;
  logic          wr_i = 1'b0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          rdata_en_o;
  logic          err_o;

  int checks = 0;
  int bad = 0;
  int model [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  spad_regfile i_spad_regfile (
    .clk(clk), .rst(rst), .sel_i(sel_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rdata_en_o(rdata_en_o), .err_o(err_o)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One bus cycle: drive at falling edge, predict from the model, compare after the rising edge
  task automatic step(input string req, input logic [SW-1:0] s, input logic r,
                      input logic w, input logic [DW-1:0] d);
    int ones;
    int idx;
    bit legal;
    int exp_data;
    int exp_en;
    int exp_err;
    @(negedge clk);
    sel_i = s; rd_i = r; wr_i = w; wdata_i = d;
    ones = 0;
    idx = NR - 1;
    for (int i = 0; i < SW; i++) if (s[i]) begin ones++; idx = i; end
    legal = (ones <= 1) && !(r && w);
    exp_en   = (r && legal) ? 1 : 0;
    exp_data = exp_en ? model[idx] : 0;
    exp_err  = ((r || w) && !legal) ? 1 : 0;
    @(posedge clk);
    if (w && legal) model[idx] = int'(d);
    #1;
    check(req, int'(rdata_o), exp_data, "rdata");
    check(req, int'(rdata_en_o), exp_en, "rdata_en");
    check(req, int'(err_o), exp_err, "err");
  endtask

  function automatic logic [SW-1:0] one_sel(input int i);
    return (i < SW) ? (SW'(1) << i) : '0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet during reset
    check("R1", int'(rdata_o), 0, "rdata in reset");
    check("R1", int'(rdata_en_o), 0, "rdata_en in reset");
    check("R1", int'(err_o), 0, "err in reset");
    @(negedge clk);
    rst = 1'b0;
    // R1: every register reads back zero after reset
    for (int i = 0; i < NR; i++) step("R1", one_sel(i), 1'b1, 1'b0, '0);
    // R2 R3 R4: fill every register through its own select, 15 by default
    for (int i = 0; i < NR; i++) step(i < SW ? "R2" : "R3", one_sel(i), 1'b0, 1'b1, DW'(16'hA100 + i * 16'h0111));
    for (int i = 0; i < NR; i++) step(i < SW ? "R5" : "R3", one_sel(i), 1'b1, 1'b0, '0);
    // R7: double select refused with either strobe
    step("R7", 15'h0003, 1'b0, 1'b1, 16'hDEAD);
    step("R7", 15'h0003, 1'b1, 1'b0, '0);
    step("R7", 15'h4001, 1'b0, 1'b1, 16'hBEEF);
    step("R7", 15'h0001, 1'b1, 1'b0, '0);
    step("R7", 15'h0002, 1'b1, 1'b0, '0);
    step("R7", 15'h4000, 1'b1, 1'b0, '0);
    // R8: both strobes, single and default select
    step("R8", 15'h0010, 1'b1, 1'b1, 16'h1234);
    step("R8", 15'h0000, 1'b1, 1'b1, 16'h5678);
    step("R8", 15'h0010, 1'b1, 1'b0, '0);
    step("R8", 15'h0000, 1'b1, 1'b0, '0);
    // R9: no strobe with several selects
    step("R9", 15'h7FFF, 1'b0, 1'b0, 16'hFFFF);
    step("R9", 15'h0000, 1'b0, 1'b0, 16'hFFFF);
    step("R6", 15'h0000, 1'b1, 1'b0, '0);
    step("R6", 15'h0000, 1'b0, 1'b0, '0);
    // R10: write then immediate read of the same register
    step("R10", one_sel(7), 1'b0, 1'b1, 16'h0F0F);
    step("R10", one_sel(7), 1'b1, 1'b0, '0);
    step("R10", 15'h0000, 1'b0, 1'b1, 16'hC3C3);
    step("R10", 15'h0000, 1'b1, 1'b0, '0);
    // Mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      int pick;
      logic [SW-1:0] s;
      pick = $urandom_range(0, 9);
      if (pick < 7) s = one_sel($urandom_range(0, NR - 1));
      else s = SW'($urandom);
      step("R4", s, 1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 2) != 0), DW'($urandom));
    end
    for (int i = 0; i < NR; i++) step("R5", one_sel(i), 1'b1, 1'b0, '0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule